// File: doc/BRIEF.md
# CAN Channel Init/Enable Sequencer

This block governs the life cycle of one CAN channel: going into initialization, leaving it, switching the channel on and switching it off. Software reaches it through a small register write port. A control word carries an enable request and an init request. A read-only status bit shows whether the channel is really running. Next to the control word sit a configuration word and a buffer-base word, which survive initialization, and a parameter word, which initialization wipes.

Setting the init request has several effects. It clears the enable request, the option bits and the parameter word. It clears the idle-detect counter, and it emits a one-cycle clear pulse that the bit and frame logic of the channel can use to reset itself. While init is held, the control word is locked. The only change accepted is the release of init, and that release is refused until the channel reports itself disabled.

An enabled channel does not go live at once. It first watches the received bit stream, one sample per bit time, until it has seen an unbroken run of recessive bits. Switching off is graceful: an active channel keeps reporting enabled until the next frame or idle boundary is signalled.

Top module: `canch_lifecycle`

## Requirements
- R1: After synchronous reset, `chan_state` is 0 (DISABLED), `status_en` is 0, `clr_pulse` is 0, and `ctl_q`, `cfg_q`, `base_q` and `par_q` are all zero.
- R2: The register addresses are: 0 for control, 1 for configuration, 2 for buffer base, 3 for parameters. In the control word, bit 0 is enable, bit 1 is init, and bits [OPT_W+1:2] are options. While init is 0, a control write stores enable and options. A write that has bit 1 set instead does the following:
  - it sets init;
  - it clears enable, the options and `par_q`;
  - it raises `clr_pulse` for exactly one cycle;
  - it leaves `cfg_q` and `base_q` unchanged.
- R3: While init is 1, a control write never changes the enable bit or the option bits.
- R4: While init is 1, a control write with bit 1 at zero clears init only if `status_en` is 0. If `status_en` is 1, init stays set.
- R5: The `chan_state` encoding is DISABLED=0, WAIT_IDLE=1, ACTIVE=2, DISABLING=3. The state moves from DISABLED to WAIT_IDLE when enable is 1 and init is 0. It returns from WAIT_IDLE to DISABLED when enable is cleared.
- R6: WAIT_IDLE moves to ACTIVE only after IDLE_BITS (default 11) consecutive recessive samples, where `rx_bit`=1 is taken on cycles with `bit_tick` high. A dominant sample restarts the count, and cycles without `bit_tick` do not count.
- R7: `status_en` becomes 1 on entry to ACTIVE. Clearing enable in ACTIVE moves the state to DISABLING with `status_en` still 1. The next `frame_bnd` then moves it to DISABLED, and `status_en` becomes 0.
- R8: `frame_bnd` has no effect on the state outside DISABLING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 config, 2 base, 3 params) |
| reg_wdata | input | DW | Write data |
| bit_tick | input | 1 | One-cycle pulse per received bit time |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| frame_bnd | input | 1 | Frame end or bus-idle boundary reached |
| ctl_q | output | OPT_W+2 | Control word (options, init, enable) |
| cfg_q | output | DW | Configuration word, kept through init |
| base_q | output | DW | Buffer base word, kept through init |
| par_q | output | DW | Parameter word, cleared by init |
| status_en | output | 1 | Channel really enabled |
| chan_state | output | 2 | Life-cycle state |
| clr_pulse | output | 1 | One-cycle clear for the channel's bit and frame logic |

## Verification
A vector table walks control writes in four situations: with init clear, with init being set, while locked, and at release. The table shows apart write-through, the wiping done by init, and the lock. The idle detector is fed three patterns:
- a run one bit short of the limit;
- a run broken by a dominant bit;
- recessive levels held without bit ticks.

These separate a correct consecutive count from one that is off by one, never restarts, or counts clock cycles. The disable path is exercised with a boundary pulse both inside and outside DISABLING, and with an early release of init. This shows that the shutdown waits for the boundary and that the release guard holds.

// File: rtl/canch_pkg.sv
package canch_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LIVE  = 2'd2,
    ST_DRAIN = 2'd3
  } chan_st_e;

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_BASE = 2'd2;
  localparam logic [1:0] A_PAR  = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_INIT = 1;
endpackage

// File: rtl/canch_ctlregs.sv
module canch_ctlregs
  import canch_pkg::*;
#(
  parameter int DW    = 16,
  parameter int OPT_W = 2,
  localparam int CTL_W = OPT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             status_en,
  output logic [CTL_W-1:0] ctl_q,
  output logic [DW-1:0]    cfg_q,
  output logic [DW-1:0]    base_q,
  output logic [DW-1:0]    par_q,
  output logic             clr_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      cfg_q     <= '0;
      base_q    <= '0;
      par_q     <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= 1'b0;
      if (wr) begin
        case (addr)
          A_CTL: begin
            if (!ctl_q[B_INIT]) begin
              if (wdata[B_INIT]) begin
                // entering init: wipe user state, keep cfg/base
                ctl_q         <= '0;
                ctl_q[B_INIT] <= 1'b1;
                par_q         <= '0;
                clr_pulse     <= 1'b1;
              end else begin
                ctl_q <= {wdata[CTL_W-1:2], 1'b0, wdata[B_EN]};
              end
            end else if (!wdata[B_INIT] && !status_en) begin
              // locked: only release, and only when disabled
              ctl_q[B_INIT] <= 1'b0;
            end
          end
          A_CFG:   cfg_q  <= wdata;
          A_BASE:  base_q <= wdata;
          default: par_q  <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/canch_idle_det.sv
module canch_idle_det #(
  parameter int IDLE_BITS = 11,
  localparam int CW = $clog2(IDLE_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  input  logic rx,
  output logic idle_ok
);
  localparam logic [CW-1:0] LIM = CW'(IDLE_BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rx)             cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
  end

  assign idle_ok = (cnt == LIM);
endmodule

// File: rtl/canch_enable_fsm.sv
module canch_enable_fsm
  import canch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_req,
  input  logic       idle_ok,
  input  logic       frame_bnd,
  output logic [1:0] state_o,
  output logic       status_en,
  output logic       run
);
  chan_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OFF;
      status_en <= 1'b0;
    end else begin
      case (st)
        ST_OFF:  if (en_req) st <= ST_WAIT;
        ST_WAIT: begin
          if (!en_req) begin
            st <= ST_OFF;
          end else if (idle_ok) begin
            st        <= ST_LIVE;
            status_en <= 1'b1;
          end
        end
        ST_LIVE: if (!en_req) st <= ST_DRAIN;
        default: begin
          if (frame_bnd) begin
            st        <= ST_OFF;
            status_en <= 1'b0;
          end
        end
      endcase
    end
  end

  assign state_o = st;
  assign run     = (st == ST_WAIT);
endmodule

// File: rtl/canch_lifecycle.sv
module canch_lifecycle
  import canch_pkg::*;
#(
  parameter int DW        = 16,
  parameter int OPT_W     = 2,
  parameter int IDLE_BITS = 11,
  localparam int CTL_W    = OPT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             bit_tick,
  input  logic             rx_bit,
  input  logic             frame_bnd,
  output logic [CTL_W-1:0] ctl_q,
  output logic [DW-1:0]    cfg_q,
  output logic [DW-1:0]    base_q,
  output logic [DW-1:0]    par_q,
  output logic             status_en,
  output logic [1:0]       chan_state,
  output logic             clr_pulse
);
  logic run, idle_ok, en_req;

  canch_ctlregs #(.DW(DW), .OPT_W(OPT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_en(status_en), .ctl_q(ctl_q), .cfg_q(cfg_q), .base_q(base_q),
    .par_q(par_q), .clr_pulse(clr_pulse)
  );

  assign en_req = ctl_q[B_EN] & ~ctl_q[B_INIT];

  canch_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .clr(clr_pulse), .run(run), .tick(bit_tick),
    .rx(rx_bit), .idle_ok(idle_ok)
  );

  canch_enable_fsm u_fsm (
    .clk(clk), .rst(rst), .en_req(en_req), .idle_ok(idle_ok),
    .frame_bnd(frame_bnd), .state_o(chan_state), .status_en(status_en),
    .run(run)
  );
endmodule

// File: rtl/canch_lifecycle_chk.sv
module canch_lifecycle_chk
  import canch_pkg::*;
#(
  parameter int DW    = 16,
  parameter int OPT_W = 2,
  localparam int CTL_W = OPT_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             frame_bnd,
  input logic [CTL_W-1:0] ctl_q,
  input logic [DW-1:0]    cfg_q,
  input logic [DW-1:0]    base_q,
  input logic [DW-1:0]    par_q,
  input logic             status_en,
  input logic [1:0]       chan_state,
  input logic             clr_pulse
);
  wire ctl_wr = reg_wr && (reg_addr == A_CTL);

  assert_init_wipes_R2: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> (ctl_q[B_INIT] && !ctl_q[B_EN] && par_q == '0));

  assert_keep_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |-> ($stable(cfg_q) && $stable(base_q)));

  assert_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_q[B_INIT]) |=>
      ($stable(ctl_q[CTL_W-1:2]) && $stable(ctl_q[B_EN])));

  assert_release_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_q[B_INIT] && status_en) |=> ctl_q[B_INIT]);

  assert_live_from_wait_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_en) |-> ($past(chan_state) == ST_WAIT && chan_state == ST_LIVE));

  assert_off_not_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_state == ST_OFF || chan_state == ST_WAIT) |-> !status_en);

  assert_drain_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (chan_state == ST_DRAIN && !frame_bnd) |=> chan_state == ST_DRAIN);
endmodule

bind canch_lifecycle canch_lifecycle_chk #(.DW(DW), .OPT_W(OPT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .frame_bnd(frame_bnd), .ctl_q(ctl_q), .cfg_q(cfg_q), .base_q(base_q),
  .par_q(par_q), .status_en(status_en), .chan_state(chan_state),
  .clr_pulse(clr_pulse)
);

// File: tb/tb_canch_lifecycle.sv
module tb_canch_lifecycle;
  localparam int DW = 16;
  localparam int OPT_W = 2;
  localparam int CTL_W = OPT_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, frame_bnd = 1'b0;
  logic [CTL_W-1:0] ctl_q;
  logic [DW-1:0] cfg_q, base_q, par_q;
  logic status_en, clr_pulse;
  logic [1:0] chan_state;

  int n_chk = 0, n_fail = 0;
  logic last_clr;

  always #2.5 clk = ~clk;

  canch_lifecycle #(.DW(DW), .OPT_W(OPT_W), .IDLE_BITS(11)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .frame_bnd(frame_bnd), .ctl_q(ctl_q), .cfg_q(cfg_q), .base_q(base_q),
    .par_q(par_q), .status_en(status_en), .chan_state(chan_state),
    .clr_pulse(clr_pulse)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    last_clr = clr_pulse;
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    bit_tick = 1'b1; rx_bit = v;
    @(negedge clk);
    bit_tick = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_bnd();
    @(negedge clk);
    frame_bnd = 1'b1;
    @(negedge clk);
    frame_bnd = 1'b0;
  endtask

  // {addr, wdata, expected ctl_q, expected par_q}
  localparam logic [37:0] VEC [9] = '{
    {2'd3, 16'h1234, 4'h0, 16'h1234}, // R2 param write
    {2'd1, 16'h00A5, 4'h0, 16'h1234}, // R2 cfg write
    {2'd2, 16'h0F00, 4'h0, 16'h1234}, // R2 base write
    {2'd0, 16'h000D, 4'hD, 16'h1234}, // R2 options+enable stored
    {2'd0, 16'h0002, 4'h2, 16'h0000}, // R2 init wipes enable/options/params
    {2'd0, 16'h000F, 4'h2, 16'h0000}, // R3 locked write ignored
    {2'd3, 16'h5555, 4'h2, 16'h5555}, // R2 params writable during init
    {2'd0, 16'h0001, 4'h0, 16'h5555}, // R4 release with status 0, enable ignored
    {2'd0, 16'h0005, 4'h5, 16'h5555}  // R2 write-through again
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 state", 32'(chan_state), 0);
    chk("R1 status", 32'(status_en), 0);
    chk("R1 ctl", 32'(ctl_q), 0);
    chk("R1 regs", 32'(cfg_q | base_q | par_q), 0);
    chk("R1 clr", 32'(clr_pulse), 0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][37:36], VEC[i][35:20]);
      chk($sformatf("R2 R3 R4 vector %0d ctl", i), 32'(ctl_q), 32'(VEC[i][19:16]));
      chk($sformatf("R2 R3 R4 vector %0d par", i), 32'(par_q), 32'(VEC[i][15:0]));
      if (i == 4) begin
        chk("R2 clr pulse raised", 32'(last_clr), 1);
        @(negedge clk);
        chk("R2 clr pulse one cycle", 32'(clr_pulse), 0);
      end
    end
    chk("R2 cfg kept", 32'(cfg_q), 32'h00A5);
    chk("R2 base kept", 32'(base_q), 32'h0F00);
    idle(2);
    chk("R5 enabled -> WAIT_IDLE", 32'(chan_state), 1);
    wr(2'd0, 16'h0000);
    idle(2);
    chk("R5 enable cleared -> DISABLED", 32'(chan_state), 0);

    // idle detection
    wr(2'd0, 16'h0001);
    idle(2);
    chk("R5 WAIT_IDLE", 32'(chan_state), 1);
    for (int i = 0; i < 10; i++) tick(1'b1);
    idle(3);
    chk("R6 ten recessive not enough", 32'(chan_state), 1);
    chk("R7 status low while waiting", 32'(status_en), 0);
    tick(1'b0);
    for (int i = 0; i < 10; i++) tick(1'b1);
    rx_bit = 1'b1;
    idle(30);
    chk("R6 dominant restarts count / no tick no count", 32'(chan_state), 1);
    tick(1'b1);
    idle(2);
    chk("R6 eleventh recessive -> ACTIVE", 32'(chan_state), 2);
    chk("R7 status high in ACTIVE", 32'(status_en), 1);

    pulse_bnd();
    idle(2);
    chk("R8 boundary ignored in ACTIVE", 32'(chan_state), 2);

    // disable through init
    wr(2'd0, 16'h0002);
    idle(2);
    chk("R7 DISABLING after enable cleared", 32'(chan_state), 3);
    chk("R7 status held in DISABLING", 32'(status_en), 1);
    wr(2'd0, 16'h0000);
    chk("R4 release refused while status 1", 32'(ctl_q), 32'h2);
    idle(10);
    chk("R7 waits for boundary", 32'(chan_state), 3);
    pulse_bnd();
    idle(1);
    chk("R7 boundary -> DISABLED", 32'(chan_state), 0);
    chk("R7 status cleared", 32'(status_en), 0);
    wr(2'd0, 16'h0000);
    chk("R4 release after disable", 32'(ctl_q), 32'h0);
    pulse_bnd();
    idle(2);
    chk("R8 boundary ignored in DISABLED", 32'(chan_state), 0);
    wr(2'd0, 16'h0001);
    idle(2);
    chk("R5 restart -> WAIT_IDLE", 32'(chan_state), 1);
    summary();
  end
endmodule